// File: doc/BRIEF.md
# Legacy FPU Error Signaling Controller

This block sits at the edge of a processor core. It reports floating-point errors the old way and signals break events. One open-drain error line, active low, does two jobs. The stop-clock request decides which job it is doing at any moment:

- **Stop-clock request inactive:** the line reports a pending unmasked floating-point error.
- **Stop-clock request active:** the line reports that a break event is waiting. The core should then leave its stopped state. A break-event indication stays on until the stop-clock request is withdrawn.

The block also decides whether the next non-control floating-point instruction gets an exception request. That decision uses three things: the pending-error flag, the ignore-numeric-error input and the numeric-error-mode control bit.

The three active-low pin inputs (stop-clock, probe request and ignore-numeric-error) are asynchronous. Each one passes through a flip-flop synchronizer before use. The error output is modelled as an output-enable: a 1 means the pad pulls the line low, and a 0 means the line is released. The other inputs are synchronous core-side strobes and levels. All state is cleared by a synchronous, active-high reset.

Top module: `fpu_err_signal`

## Requirements
- R1: While reset is high and on the cycle after reset, `err_pin_oe_o` is 0 and `fp_exc_req_o` is 0. Both the pending-error flag and the break flag are cleared.
- R2: The active-low pins `stop_clk_n_i`, `probe_req_n_i` and `ignore_err_n_i` take effect through a two-stage synchronizer. A level sampled at clock edge k is used by the logic from edge k+2 onward.
- R3: While the synchronized stop-clock request is inactive, `err_pin_oe_o` is 1 exactly when a floating-point error is pending.
- R4: A pulse on `fp_err_evt_i` sets the pending-error flag at the next edge. The flag stays set until an `err_clr_i` strobe. If a new error and a clear arrive in the same cycle, the flag stays set.
- R5: While the synchronized stop-clock request is active, `err_pin_oe_o` shows the break flag. Any bit of `brk_evt_i` that is high at an edge sets that flag.
- R6: A synchronized probe request that is asserted while stop-clock is active counts as a break event.
- R7: Once set, the break flag holds for as long as stop-clock stays active. It is cleared at the first edge where stop-clock is seen inactive, and the line then reverts to showing the pending-error flag.
- R8: Break sources and probe requests that occur while stop-clock is inactive leave no trace. A later stop-clock assertion with no new source keeps `err_pin_oe_o` at 0.
- R9: With `ne_mode_i` = 0 and the synchronized ignore input asserted, an `fp_issue_i` strobe never produces `fp_exc_req_o`.
- R10: With the ignore input deasserted and an error pending, `fp_exc_req_o` is 1 for one cycle, one cycle after the `fp_issue_i` strobe.
- R11: With `ne_mode_i` = 1, the ignore input has no effect. A pending error always yields `fp_exc_req_o` one cycle after an `fp_issue_i` strobe.
- R12: Without a pending error, `fp_exc_req_o` stays 0 whatever the strobes and modes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| fp_err_evt_i | input | 1 | Unmasked floating-point error detected (pulse) |
| err_clr_i | input | 1 | Clears the pending-error flag (pulse) |
| stop_clk_n_i | input | 1 | Stop-clock request, active low, asynchronous |
| probe_req_n_i | input | 1 | Probe request, active low, asynchronous |
| ignore_err_n_i | input | 1 | Ignore-numeric-error, active low, asynchronous |
| ne_mode_i | input | 1 | Numeric-error-mode control bit; 1 disables the ignore input |
| fp_issue_i | input | 1 | Issue strobe of a non-control floating-point instruction |
| brk_evt_i | input | BRK_W | Break-event sources, any bit counts |
| err_pin_oe_o | output | 1 | 1 = error line pulled low, 0 = released |
| fp_exc_req_o | output | 1 | Floating-point exception request, one-cycle pulse |

## Verification
The assertions check the following on every cycle, using the synchronized pin levels:
- an error sets the pending flag at the next edge;
- the break flag holds while stop-clock is active and can never survive an inactive stop-clock;
- a probe during stop-clock sets the break flag;
- every exception request follows an issue strobe that saw a pending error;
- the mode bit and the ignore input gate the exception request as required.

The bench's scenarios cover the rest:
- the two-cycle synchronizer latency;
- the switch of the error line's meaning when stop-clock changes;
- clear and set arriving in the same cycle;
- the rule that sources seen before a stop-clock request are forgotten.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned PIN_COUNT      = 3;

  // Synchronized pin view, active-high polarity
  typedef struct packed {
    logic stop;
    logic probe;
    logic ignore;
  } pin_view_t;

  // Exception gate: pending error plus issue, unless ignored (mode bit overrides ignore)
  function automatic logic exc_gate(input logic pend, input logic issue,
                                    input logic ne_mode, input logic ign);
    return issue & pend & (ne_mode | ~ign);
  endfunction

  // Error line meaning selected by stop-clock
  function automatic logic line_select(input logic stop, input logic brk, input logic err);
    return stop ? brk : err;
  endfunction

  // Next value of the sticky break flag
  function automatic logic brk_next(input logic stop, input logic cur, input logic hit);
    if (!stop) return 1'b0;
    return cur | hit;
  endfunction

  // Next value of the pending-error flag: set dominates clear
  function automatic logic err_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/fes_sync.sv
module fes_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/fes_err_track.sv
module fes_err_track
  import fes_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic err_set_i,
  input  logic err_clr_i,
  input  logic issue_i,
  input  logic ne_mode_i,
  input  logic ign_act_i,
  output logic err_pend_o,
  output logic exc_fire_o,
  output logic exc_q_o
);

  logic err_q;
  logic err_d;

  assign err_d      = err_next(err_q, err_set_i, err_clr_i);
  assign exc_fire_o = exc_gate(err_q, issue_i, ne_mode_i, ign_act_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= 1'b0;
      exc_q_o <= 1'b0;
    end else begin
      err_q   <= err_d;
      exc_q_o <= exc_fire_o;
    end
  end

  assign err_pend_o = err_q;

endmodule

// File: rtl/fes_brk_track.sv
module fes_brk_track
  import fes_pkg::*;
#(
  parameter int unsigned BRK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_act_i,
  input  logic             probe_act_i,
  input  logic [BRK_W-1:0] brk_src_i,
  output logic             brk_hit_o,
  output logic             brk_pend_o
);

  logic brk_q;
  logic src_any;

  assign src_any   = |brk_src_i;
  assign brk_hit_o = stop_act_i & (src_any | probe_act_i);

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= brk_next(stop_act_i, brk_q, brk_hit_o);
  end

  assign brk_pend_o = brk_q;

endmodule

// File: rtl/fpu_err_signal.sv
module fpu_err_signal
  import fes_pkg::*;
#(
  parameter int unsigned BRK_W      = 4,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fp_err_evt_i,
  input  logic             err_clr_i,
  input  logic             stop_clk_n_i,
  input  logic             probe_req_n_i,
  input  logic             ignore_err_n_i,
  input  logic             ne_mode_i,
  input  logic             fp_issue_i,
  input  logic [BRK_W-1:0] brk_evt_i,
  output logic             err_pin_oe_o,
  output logic             fp_exc_req_o
);

  localparam int unsigned PW = PIN_COUNT;

  logic [PW-1:0] pins_raw_n;
  logic [PW-1:0] pins_sync_n;
  pin_view_t     pv;

  // Named internal events for the checker
  logic stop_act;
  logic probe_act;
  logic ign_act;
  logic err_pend;
  logic brk_pend;
  logic brk_hit;
  logic exc_fire;

  assign pins_raw_n = {stop_clk_n_i, probe_req_n_i, ignore_err_n_i};

  fes_sync #(
    .STAGES (SYNC_DEPTH),
    .WIDTH  (PW),
    .RST_VAL({PW{1'b1}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pins_raw_n),
    .q_o (pins_sync_n)
  );

  assign pv        = pin_view_t'(~pins_sync_n);
  assign stop_act  = pv.stop;
  assign probe_act = pv.probe;
  assign ign_act   = pv.ignore;

  fes_err_track u_err (
    .clk        (clk),
    .rst        (rst),
    .err_set_i  (fp_err_evt_i),
    .err_clr_i  (err_clr_i),
    .issue_i    (fp_issue_i),
    .ne_mode_i  (ne_mode_i),
    .ign_act_i  (ign_act),
    .err_pend_o (err_pend),
    .exc_fire_o (exc_fire),
    .exc_q_o    (fp_exc_req_o)
  );

  fes_brk_track #(.BRK_W(BRK_W)) u_brk (
    .clk         (clk),
    .rst         (rst),
    .stop_act_i  (stop_act),
    .probe_act_i (probe_act),
    .brk_src_i   (brk_evt_i),
    .brk_hit_o   (brk_hit),
    .brk_pend_o  (brk_pend)
  );

  assign err_pin_oe_o = line_select(stop_act, brk_pend, err_pend);

endmodule

// File: rtl/fes_checker.sv
module fes_checker (
  input logic clk,
  input logic rst,
  input logic fp_err_evt_i,
  input logic fp_issue_i,
  input logic ne_mode_i,
  input logic fp_exc_req_o,
  input logic stop_act,
  input logic probe_act,
  input logic ign_act,
  input logic err_pend,
  input logic brk_pend
);

  assert_err_latch_R4: assert property (@(posedge clk) disable iff (rst)
    fp_err_evt_i |=> err_pend);

  assert_brk_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stop_act && brk_pend) |=> brk_pend);

  assert_brk_forget_R8: assert property (@(posedge clk) disable iff (rst)
    !stop_act |=> !brk_pend);

  assert_probe_brk_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_act && probe_act) |=> brk_pend);

  assert_exc_cause_R12: assert property (@(posedge clk) disable iff (rst)
    fp_exc_req_o |-> $past(fp_issue_i && err_pend));

  assert_mode_override_R11: assert property (@(posedge clk) disable iff (rst)
    (ne_mode_i && fp_issue_i && err_pend) |=> fp_exc_req_o);

  assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (!ne_mode_i && ign_act && fp_issue_i) |=> !fp_exc_req_o);

  assert_no_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (!ign_act && fp_issue_i && err_pend) |=> fp_exc_req_o);

endmodule

bind fpu_err_signal fes_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .fp_err_evt_i (fp_err_evt_i),
  .fp_issue_i   (fp_issue_i),
  .ne_mode_i    (ne_mode_i),
  .fp_exc_req_o (fp_exc_req_o),
  .stop_act     (stop_act),
  .probe_act    (probe_act),
  .ign_act      (ign_act),
  .err_pend     (err_pend),
  .brk_pend     (brk_pend)
);

// File: tb/fpu_err_signal_tb_top.sv
`timescale 1ns/1ps
module fpu_err_signal_tb_top;

  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fp_err_evt_i = 1'b0, err_clr_i = 1'b0;
  logic stop_clk_n_i = 1'b1, probe_req_n_i = 1'b1, ignore_err_n_i = 1'b1;
  logic ne_mode_i = 1'b0, fp_issue_i = 1'b0;
  logic [BW-1:0] brk_evt_i = '0;
  logic err_pin_oe_o, fp_exc_req_o;

  always #2.5 clk = ~clk;

  fpu_err_signal #(.BRK_W(BW)) dut_i (
    .clk(clk), .rst(rst), .fp_err_evt_i(fp_err_evt_i), .err_clr_i(err_clr_i),
    .stop_clk_n_i(stop_clk_n_i), .probe_req_n_i(probe_req_n_i),
    .ignore_err_n_i(ignore_err_n_i), .ne_mode_i(ne_mode_i),
    .fp_issue_i(fp_issue_i), .brk_evt_i(brk_evt_i),
    .err_pin_oe_o(err_pin_oe_o), .fp_exc_req_o(fp_exc_req_o)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    started = 0;
  bit    finished = 0;

  // Reference model: pin histories kept as queues, newest sample first
  logic stop_h[$], probe_h[$], ign_h[$];
  bit   m_err, m_brk, m_exc, m_pin;

  initial begin
    stop_h = '{1'b1, 1'b1};
    probe_h = '{1'b1, 1'b1};
    ign_h = '{1'b1, 1'b1};
  end

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_err = 0; m_brk = 0; m_exc = 0;
      stop_h = '{1'b1, 1'b1};
      probe_h = '{1'b1, 1'b1};
      ign_h = '{1'b1, 1'b1};
    end else begin
      bit stop_on, probe_on, ign_on;
      stop_on  = (stop_h[1] == 1'b0);
      probe_on = (probe_h[1] == 1'b0);
      ign_on   = (ign_h[1] == 1'b0);
      m_exc = fp_issue_i && m_err && (ne_mode_i || !ign_on);
      if (!stop_on) m_brk = 0;
      else if ((brk_evt_i != 0) || probe_on) m_brk = 1;
      if (fp_err_evt_i) m_err = 1;
      else if (err_clr_i) m_err = 0;
      stop_h.push_front(stop_clk_n_i);   void'(stop_h.pop_back());
      probe_h.push_front(probe_req_n_i); void'(probe_h.pop_back());
      ign_h.push_front(ignore_err_n_i);  void'(ign_h.pop_back());
    end
    m_pin = (stop_h[1] == 1'b0) ? m_brk : m_err;
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      n_vec++;
      if (err_pin_oe_o !== m_pin) begin
        n_bad++;
        $display("FAIL %s err_pin_oe_o actual=%b expected=%b t=%0t", cur_req, err_pin_oe_o, m_pin, $time);
      end
      n_vec++;
      if (fp_exc_req_o !== m_exc) begin
        n_bad++;
        $display("FAIL %s fp_exc_req_o actual=%b expected=%b t=%0t", cur_req, fp_exc_req_o, m_exc, $time);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_err();
    @(negedge clk); fp_err_evt_i = 1; @(negedge clk); fp_err_evt_i = 0;
  endtask

  task automatic pulse_issue();
    @(negedge clk); fp_issue_i = 1; @(negedge clk); fp_issue_i = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr_i = 1; @(negedge clk); err_clr_i = 0;
  endtask

  task automatic pulse_brk(input logic [BW-1:0] v);
    @(negedge clk); brk_evt_i = v; @(negedge clk); brk_evt_i = '0;
  endtask

  initial begin
    cur_req = "R1";
    idle(4);
    rst = 0;
    idle(3);

    cur_req = "R3";  pulse_err(); idle(3);
    cur_req = "R10"; pulse_issue(); idle(3);
    cur_req = "R9";  ignore_err_n_i = 0; idle(3); pulse_issue(); idle(3);
    cur_req = "R11"; ne_mode_i = 1; pulse_issue(); idle(3);
    ne_mode_i = 0; ignore_err_n_i = 1; idle(3);

    cur_req = "R4";  pulse_clr(); idle(2);
    cur_req = "R12"; pulse_issue(); ne_mode_i = 1; pulse_issue(); ne_mode_i = 0; idle(2);
    cur_req = "R4";
    @(negedge clk); fp_err_evt_i = 1; err_clr_i = 1;
    @(negedge clk); fp_err_evt_i = 0; err_clr_i = 0;
    idle(3);
    pulse_clr(); idle(2);

    cur_req = "R8";  pulse_brk(4'b0010); probe_req_n_i = 0; idle(2); probe_req_n_i = 1; idle(4);
    cur_req = "R2";  stop_clk_n_i = 0; idle(5);
    cur_req = "R5";  pulse_brk(4'b1000); idle(5);
    cur_req = "R7";  pulse_err(); idle(3);
    stop_clk_n_i = 1; idle(5);
    pulse_clr(); idle(2);

    cur_req = "R6";  stop_clk_n_i = 0; idle(4);
    probe_req_n_i = 0; @(negedge clk); probe_req_n_i = 1; idle(6);
    stop_clk_n_i = 1; idle(4);

    cur_req = "R5";
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        fp_err_evt_i   = (lf[3:0] == 4'h5);
        err_clr_i      = (lf[7:4] == 4'h9);
        fp_issue_i     = lf[8] & lf[2];
        ne_mode_i      = lf[11] & lf[12];
        brk_evt_i      = (lf[15:13] == 3'b111) ? lf[3:0] : '0;
        if (lf[6:0] == 7'h11) stop_clk_n_i = ~stop_clk_n_i;
        if (lf[5:0] == 6'h2A) ignore_err_n_i = ~ignore_err_n_i;
        probe_req_n_i  = ~(lf[14:10] == 5'h1F);
      end
    end
    @(negedge clk);
    fp_err_evt_i = 0; err_clr_i = 0; fp_issue_i = 0; brk_evt_i = '0;
    idle(4);

    cur_req = "R1";
    rst = 1; idle(3); rst = 0; idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog %s actual=hung expected=done", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule